// File: doc/BRIEF.md
# Strap-Configured Bus Clock Divider with Stop Gate

This block produces the system bus clock from the fast processor clock. The processor clock runs at twice the input clock. The divide ratio and an input frequency-range code are not set by software. They are read from four pins that also serve as the low data bus. While reset is held low, those pins carry the configuration. The values present at the moment reset is released stay in force until the next reset. The bus clock then runs at one half, one third or one quarter of the processor clock. An enable pulse marks the processor cycle that begins with each bus-clock rising edge.

The block also controls a core-clock enable for a low-power stop state. A stop request turns the enable off and an interrupt turns it back on. Neither change takes effect at once: each waits for the next bus-clock rising edge, so the core never sees a shortened bus period. The divider keeps running while the core is stopped, so restart needs no relock and no new configuration. An interrupt pulse that arrives mid-period is remembered until the boundary.

Top module: `strap_bus_clk_gen`

## Requirements
- R1: While rst_ni is low, strap_data_i is sampled on every clock: bits [1:0] give the divide code and bits [3:2] give the frequency-range code. The last value sampled before rst_ni rises is kept, and later changes on strap_data_i have no effect until the next reset.
- R2: freq_range_o shows the kept bits [3:2] and does not change between resets.
- R3: Divide code 2'b01 gives a bus period of 2 processor cycles: 1 cycle high and 1 cycle low.
- R4: Divide code 2'b10 gives a period of 3 cycles: 1 cycle high and 2 cycles low.
- R5: Divide code 2'b11 gives a period of 4 cycles: 2 cycles high and 2 cycles low.
- R6: The reserved divide code 2'b00 behaves as divide-by-2.
- R7: While reset is low, bus_clk_o and bus_clk_en_o are 0 and core_clk_en_o is 1. The first bus-clock rising edge comes on the first processor clock edge after reset is released.
- R8: bus_clk_en_o is high for exactly the one processor cycle that begins with each bus_clk_o rising edge, and low at all other times.
- R9: A stop request turns core_clk_en_o off on the next bus-clock rising edge, within one bus period. bus_clk_o keeps toggling while the core is stopped.
- R10: An interrupt while the core is stopped turns core_clk_en_o back on at the next bus-clock rising edge. A one-cycle pulse that arrives between boundaries is held until that edge and does not act before it.
- R11: An interrupt that arrives while a stop is still waiting for its boundary cancels that stop. An interrupt while the core is running with no stop waiting has no effect, and a later stop still takes effect.
- R12: core_clk_en_o changes only on clock edges where bus_clk_o rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock (twice the input clock) |
| rst_ni | input | 1 | Active-low asynchronous reset from the reset pin |
| strap_data_i | input | 4 | Shared data/strap bus; carries the configuration while reset is low |
| stop_req_i | input | 1 | Request to stop the core clock |
| wake_irq_i | input | 1 | Interrupt wake request |
| bus_clk_o | output | 1 | Divided bus clock |
| bus_clk_en_o | output | 1 | One-cycle pulse in the processor cycle that begins with a bus rising edge |
| core_clk_en_o | output | 1 | Enable for the gated processor clock |
| freq_range_o | output | 2 | Latched input-frequency range code |

## Verification
The divider is run under all four divide codes, each with a different frequency-range code. Every processor cycle of several bus periods is compared with the expected high/low shape and enable position. This tells apart the odd 1-high/2-low shape from a symmetric one, the reserved code from a real ratio, and the first edge after reset from a delayed start. After each reset release the strap pins are toggled, to show that data traffic does not reach the kept configuration. The stop gate is driven with pulses placed just after a boundary. This separates an immediate response from one held to the next bus edge. Further runs cover an interrupt that cancels a waiting stop and an interrupt that arrives while the core is running, which must change nothing.

// File: rtl/bclk_pkg.sv
package bclk_pkg;
  localparam int unsigned STRAP_W = 4;
  localparam int unsigned MAX_DIV = 4;
  localparam int unsigned RATIO_W = $clog2(MAX_DIV) + 1;

  typedef enum logic [1:0] {
    DIV_RSVD = 2'b00,
    DIV_BY2  = 2'b01,
    DIV_BY3  = 2'b10,
    DIV_BY4  = 2'b11
  } div_code_e;

  // MSBs carry the range code, LSBs the divide code
  typedef struct packed {
    logic [1:0] freq;
    div_code_e  div;
  } strap_cfg_t;

  function automatic logic [RATIO_W-1:0] ratio_of(div_code_e c);
    case (c)
      DIV_BY3: ratio_of = RATIO_W'(3);
      DIV_BY4: ratio_of = RATIO_W'(4);
      default: ratio_of = RATIO_W'(2);
    endcase
  endfunction
endpackage

// File: rtl/strap_cfg_latch.sv
module strap_cfg_latch
  import bclk_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [STRAP_W-1:0] strap_i,
  output strap_cfg_t         cfg_o
);
  strap_cfg_t cfg_q;

  // follows the pins while reset is low, frozen after release
  always_ff @(posedge clk_i) begin
    if (!rst_ni) cfg_q <= strap_cfg_t'(strap_i);
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/bus_clk_divider.sv
module bus_clk_divider #(
  parameter int unsigned MAX_DIV = 4,
  localparam int unsigned PH_W   = (MAX_DIV > 2) ? $clog2(MAX_DIV) : 1,
  localparam int unsigned RAT_W  = $clog2(MAX_DIV) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [RAT_W-1:0] ratio_i,
  output logic             bus_clk_o,
  output logic             bus_en_o,
  output logic             boundary_o
);
  logic [PH_W-1:0]  ph_q;
  logic [RAT_W-1:0] ph_ext, hi_len, last_ph;
  logic             at_last;

  assign ph_ext     = RAT_W'(ph_q);
  assign hi_len     = ratio_i >> 1;
  assign last_ph    = ratio_i - RAT_W'(1);
  assign at_last    = (ph_ext == last_ph);
  assign boundary_o = (ph_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q      <= '0;
      bus_clk_o <= 1'b0;
      bus_en_o  <= 1'b0;
    end else begin
      bus_clk_o <= (ph_ext < hi_len);
      bus_en_o  <= boundary_o;
      ph_q      <= at_last ? '0 : ph_q + PH_W'(1);
    end
  end
endmodule

// File: rtl/core_clk_gate.sv
module core_clk_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic boundary_i,
  input  logic stop_req_i,
  input  logic wake_irq_i,
  output logic run_o
);
  logic run_q, stop_pend_q, wake_pend_q;
  logic stop_any, wake_any;

  assign stop_any = run_q & (stop_pend_q | stop_req_i);
  // a wake only counts once a stop is pending or active
  assign wake_any = wake_pend_q | (wake_irq_i & (~run_q | stop_any));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q       <= 1'b1;
      stop_pend_q <= 1'b0;
      wake_pend_q <= 1'b0;
    end else if (boundary_i) begin
      if (run_q) begin
        if (stop_any && !wake_any) run_q <= 1'b0;
      end else if (wake_any) begin
        run_q <= 1'b1;
      end
      stop_pend_q <= 1'b0;
      wake_pend_q <= 1'b0;
    end else begin
      stop_pend_q <= stop_any;
      wake_pend_q <= wake_any;
    end
  end

  assign run_o = run_q;
endmodule

// File: rtl/strap_bus_clk_gen.sv
module strap_bus_clk_gen
  import bclk_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [STRAP_W-1:0] strap_data_i,
  input  logic               stop_req_i,
  input  logic               wake_irq_i,
  output logic               bus_clk_o,
  output logic               bus_clk_en_o,
  output logic               core_clk_en_o,
  output logic [1:0]         freq_range_o
);
  strap_cfg_t         cfg;
  logic [RATIO_W-1:0] ratio;
  logic               boundary;

  strap_cfg_latch i_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strap_i (strap_data_i),
    .cfg_o   (cfg)
  );

  assign ratio        = ratio_of(cfg.div);
  assign freq_range_o = cfg.freq;

  bus_clk_divider #(.MAX_DIV(MAX_DIV)) i_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ratio_i    (ratio),
    .bus_clk_o  (bus_clk_o),
    .bus_en_o   (bus_clk_en_o),
    .boundary_o (boundary)
  );

  core_clk_gate i_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .boundary_i (boundary),
    .stop_req_i (stop_req_i),
    .wake_irq_i (wake_irq_i),
    .run_o      (core_clk_en_o)
  );
endmodule

// File: rtl/bclk_checker.sv
module bclk_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bus_clk_o,
  input logic       bus_clk_en_o,
  input logic       core_clk_en_o,
  input logic [1:0] freq_range_o
);
  a_r12_gate_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(core_clk_en_o) |-> bus_clk_en_o);

  a_r8_en_in_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_clk_en_o |-> bus_clk_o);

  a_r8_rise_has_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_clk_o) |-> bus_clk_en_o);

  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_clk_en_o |=> !bus_clk_en_o);

  a_r2_range_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(freq_range_o));
endmodule

bind strap_bus_clk_gen bclk_checker i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .bus_clk_o     (bus_clk_o),
  .bus_clk_en_o  (bus_clk_en_o),
  .core_clk_en_o (core_clk_en_o),
  .freq_range_o  (freq_range_o)
);

// File: tb/test_strap_bus_clk_gen.sv
module test_strap_bus_clk_gen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] strap;
  logic       stop_req, wake_irq;
  logic       bus_clk, bus_en, core_en;
  logic [1:0] freq;

  int total = 0;
  int bad   = 0;

  typedef struct {
    logic  bc;
    logic  en;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  strap_bus_clk_gen i_strap_bus_clk_gen (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .strap_data_i  (strap),
    .stop_req_i    (stop_req),
    .wake_irq_i    (wake_irq),
    .bus_clk_o     (bus_clk),
    .bus_clk_en_o  (bus_en),
    .core_clk_en_o (core_en),
    .freq_range_o  (freq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: compares divider output with queued expectation
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(bus_clk === e.bc && bus_en === e.en, e.tag,
            int'({bus_clk, bus_en}), int'({e.bc, e.en}));
    end
  end

  task automatic do_reset(input logic [1:0] fr, input logic [1:0] dc);
    @(negedge clk);
    rst_n = 1'b0; strap = {fr, dc}; stop_req = 1'b0; wake_irq = 1'b0;
    repeat (3) @(negedge clk);
    check(bus_clk === 1'b0 && bus_en === 1'b0 && core_en === 1'b1, "R7 reset state",
          int'({bus_clk, bus_en, core_en}), 1);
    rst_n = 1'b1;
  endtask

  // driver: pushes expected bus clock shape after reset release
  task automatic run_cfg(input logic [1:0] fr, input logic [1:0] dc, input int n, input string tag);
    do_reset(fr, dc);
    @(posedge clk);
    for (int i = 0; i < 4 * n; i++) begin
      exp_t e;
      e.bc = ((i % n) < (n / 2));
      e.en = ((i % n) == 0);
      e.tag = tag;
      exp_q.push_back(e);
    end
    @(negedge clk);
    strap = ~{fr, dc}; // R1: data traffic after release
    wait (exp_q.size() == 0);
    @(negedge clk);
    check(freq === fr, "R2 range code", int'(freq), int'(fr));
  endtask

  task automatic wait_core(input logic val, output int cyc);
    cyc = 0;
    while (core_en !== val && cyc < 20) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic pulse_stop();
    stop_req = 1'b1; @(negedge clk); stop_req = 1'b0;
  endtask

  task automatic pulse_wake();
    wake_irq = 1'b1; @(negedge clk); wake_irq = 1'b0;
  endtask

  task automatic align_boundary();
    @(negedge clk);
    while (bus_en !== 1'b1) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    int cyc, pulses;
    rst_n = 1'b0; strap = 4'h0; stop_req = 1'b0; wake_irq = 1'b0;

    run_cfg(2'b10, 2'b01, 2, "R3 div2 shape (R1 R7 R8)");
    run_cfg(2'b01, 2'b10, 3, "R4 div3 shape (R1 R7 R8)");
    run_cfg(2'b11, 2'b11, 4, "R5 div4 shape (R1 R7 R8)");
    run_cfg(2'b00, 2'b00, 2, "R6 reserved code div2");

    // gate tests at divide-by-3
    do_reset(2'b01, 2'b10);
    repeat (5) @(negedge clk);

    // R9: stop at next boundary, bus keeps running
    pulse_stop();
    wait_core(1'b0, cyc);
    check(cyc <= 2, "R9 stop latency", cyc, 2);
    check(bus_en === 1'b1, "R12 stop on bus edge", int'(bus_en), 1);
    pulses = 0;
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      if (bus_en === 1'b1) pulses++;
    end
    check(pulses == 3 && core_en === 1'b0, "R9 bus runs while stopped", pulses, 3);

    // R10: wake pulse held until boundary
    align_boundary();
    pulse_wake();
    check(core_en === 1'b0, "R10 wake not immediate", int'(core_en), 0);
    @(negedge clk);
    check(core_en === 1'b0, "R10 wake held", int'(core_en), 0);
    @(negedge clk);
    check(core_en === 1'b1 && bus_en === 1'b1, "R10 wake at boundary",
          int'({core_en, bus_en}), 3);

    // R11: wake while running has no effect
    repeat (2) @(negedge clk);
    pulse_wake();
    repeat (6) @(negedge clk);
    check(core_en === 1'b1, "R11 wake while running", int'(core_en), 1);
    pulse_stop();
    wait_core(1'b0, cyc);
    check(cyc <= 2 && core_en === 1'b0, "R11 later stop still works", cyc, 2);
    pulse_wake();
    wait_core(1'b1, cyc);
    check(cyc <= 2 && core_en === 1'b1, "R10 restart", cyc, 2);

    // R11: wake cancels a waiting stop
    align_boundary();
    pulse_stop();
    pulse_wake();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(core_en === 1'b1, "R11 cancel pending stop", int'(core_en), 1);
    end
    check(freq === 2'b01, "R2 range kept through stop", int'(freq), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule